// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Slice

This block holds the control and status registers of a single DMA channel. Software starts the channel, selects linked-descriptor operation, chooses whether the channel waits for block completion, fires a software request, and pauses or resumes the channel. When software pauses the channel, the block raises a pause request towards the transfer engine. It reports the channel as paused only after the engine has no beat in flight.

The engine reports five kinds of event as single-cycle pulses: fragment done, block done, transaction done, list done and configuration error. Each event sets a sticky status flag, and software clears a flag by writing one to it. An interrupt line combines the flags that are enabled. A transfer-complete output compares the highest pending enabled event level against a two-bit request mode. The register bank sits at a base offset of 0x1000 plus 0x40 times the channel index, and addresses outside that bank are ignored.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Only byte addresses in [BASE, BASE+0x40), where BASE = 0x1000 + 0x40*CHAN_IDX, respond. Writes outside this range change nothing, and reads outside it return 0.
- R2: The configuration word at offset 0x08 holds three bits: channel enable at bit 0, linked mode at bit 4, and no-wait-for-block-done at bit 24. These drive `chan_en`, `llist_en` and `no_wait_bdone`. All other bits read 0.
- R3: Writing 1 to bit 0 of the request word at offset 0x04 makes `sw_req_pulse` high for exactly the one cycle after the write edge. Writing 0 gives no pulse. The word always reads 0.
- R4: Bit 0 of the pause word at offset 0x00 is stored and drives `pause_req`. Bit 2 of the same word, and the `paused` output, rise at the first clock edge after the request edge at which `beat_busy` is low. Both fall at the edge that writes bit 0 to zero. Other bits read 0.
- R5: The interrupt word at offset 0x0C holds the enables at bits 3:0, in the order fragment, block, transaction, list. These enables are read/write. Bit 4, the configuration-error enable, always reads 1 and cannot be cleared. Reset value of the word: 0x10.
- R6: An input pulse on `evt[k]` sets status bit 16+k of the interrupt word at the next edge, whether or not its enable is set. The order of `evt` is fragment (0), block (1), transaction (2), list (3), configuration error (4).
- R7: Writing 1 to bit 24+k of the interrupt word clears status bit 16+k. Writing 0 there leaves the status bit unchanged. Bits 28:24 always read 0.
- R8: If a status bit is set by an event and cleared by a write in the same cycle, it ends up set.
- R9: `irq` is high exactly when some status flag is set and its enable is set.
- R10: The request mode is bits 25:24 of the word at offset 0x18. Pending levels are fragment=1, block=2, transaction=3, list=4 and configuration error=5, counting only flags whose enable is set. `xfer_done` is high when the highest such level is nonzero and is at least mode+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| evt | input | 5 | Event pulses from the transfer engine |
| beat_busy | input | 1 | Engine has a beat in flight |
| chan_en | output | 1 | Channel enable |
| llist_en | output | 1 | Linked-descriptor mode |
| no_wait_bdone | output | 1 | Do not wait for block completion |
| sw_req_pulse | output | 1 | One-cycle software request |
| pause_req | output | 1 | Pause request to the engine |
| paused | output | 1 | Pause acknowledged |
| irq | output | 1 | Interrupt line |
| xfer_done | output | 1 | Transfer complete for the programmed mode |

## Verification
Two situations are hard to reach from the ports. The first is a status flag being set and cleared in the same cycle, so the bench drives an event pulse and a write-one-to-clear of the same flag in one cycle. The second is the pause acknowledge arriving late: the bench holds `beat_busy` high for several cycles after the pause write, then releases it and checks that the acknowledge follows only at the next edge. Completion is swept over all four modes and all 32 status patterns. The interrupt line is swept over every enable mask with each single source.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int BANK_BASE   = 'h1000,
  parameter int BANK_STRIDE = 'h40,
  parameter int CHAN_IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [4:0]        evt,
  input  logic              beat_busy,
  output logic              chan_en,
  output logic              llist_en,
  output logic              no_wait_bdone,
  output logic              sw_req_pulse,
  output logic              pause_req,
  output logic              paused,
  output logic              irq,
  output logic              xfer_done
);

  localparam int OFS_W = $clog2(BANK_STRIDE);
  localparam logic [ADDR_W-1:0] BANK_LO  = ADDR_W'(BANK_BASE + CHAN_IDX * BANK_STRIDE);
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(BANK_STRIDE);
  localparam logic [OFS_W-1:0] OFS_PAUSE = OFS_W'('h00);
  localparam logic [OFS_W-1:0] OFS_REQ   = OFS_W'('h04);
  localparam logic [OFS_W-1:0] OFS_CFG   = OFS_W'('h08);
  localparam logic [OFS_W-1:0] OFS_INT   = OFS_W'('h0C);
  localparam logic [OFS_W-1:0] OFS_MODE  = OFS_W'('h18);

  logic [ADDR_W-1:0] wr_rel, rd_rel;
  logic              wr_hit, rd_hit;
  logic              wr_pause, wr_req, wr_cfg, wr_int, wr_mode;
  logic [4:0]        sts, sts_clr, ie_full, pend;
  logic [3:0]        ie;
  logic [1:0]        mode;
  logic [2:0]        level;
  logic              pause_d;

  assign wr_rel = wr_addr - BANK_LO;
  assign rd_rel = rd_addr - BANK_LO;
  assign wr_hit = wr_en && (wr_rel < STRIDE_A);
  assign rd_hit = rd_rel < STRIDE_A;

  assign wr_pause = wr_hit && (wr_rel[OFS_W-1:0] == OFS_PAUSE);
  assign wr_req   = wr_hit && (wr_rel[OFS_W-1:0] == OFS_REQ);
  assign wr_cfg   = wr_hit && (wr_rel[OFS_W-1:0] == OFS_CFG);
  assign wr_int   = wr_hit && (wr_rel[OFS_W-1:0] == OFS_INT);
  assign wr_mode  = wr_hit && (wr_rel[OFS_W-1:0] == OFS_MODE);

  assign sts_clr = wr_int ? wr_data[28:24] : 5'b0;
  assign pause_d = wr_pause ? wr_data[0] : pause_req;
  assign ie_full = {1'b1, ie};
  assign pend    = sts & ie_full;
  assign irq     = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en       <= 1'b0;
      llist_en      <= 1'b0;
      no_wait_bdone <= 1'b0;
      ie            <= '0;
      mode          <= '0;
      sts           <= '0;
      pause_req     <= 1'b0;
      paused        <= 1'b0;
      sw_req_pulse  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        chan_en       <= wr_data[0];
        llist_en      <= wr_data[4];
        no_wait_bdone <= wr_data[24];
      end
      if (wr_int)  ie   <= wr_data[3:0];
      if (wr_mode) mode <= wr_data[25:24];
      sts          <= (sts & ~sts_clr) | evt;
      pause_req    <= pause_d;
      paused       <= pause_d && pause_req && (paused || !beat_busy);
      sw_req_pulse <= wr_req && wr_data[0];
    end
  end

  always_comb begin
    if (pend[4])      level = 3'd5;
    else if (pend[3]) level = 3'd4;
    else if (pend[2]) level = 3'd3;
    else if (pend[1]) level = 3'd2;
    else if (pend[0]) level = 3'd1;
    else              level = 3'd0;
  end

  assign xfer_done = (level != 3'd0) && (level >= ({1'b0, mode} + 3'd1));

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      case (rd_rel[OFS_W-1:0])
        OFS_PAUSE: rd_data = {29'b0, paused, 1'b0, pause_req};
        OFS_CFG:   rd_data = {7'b0, no_wait_bdone, 19'b0, llist_en, 3'b0, chan_en};
        OFS_INT:   rd_data = {11'b0, sts, 11'b0, ie_full};
        OFS_MODE:  rd_data = {6'b0, mode, 24'b0};
        default:   rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BANK_LO = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [4:0]        evt,
  input logic              beat_busy,
  input logic              chan_en,
  input logic              pause_req,
  input logic              paused,
  input logic              sw_req_pulse,
  input logic              irq,
  input logic              xfer_done,
  input logic [4:0]        sts,
  input logic [3:0]        ie
);

  logic [ADDR_W-1:0] rel;
  logic              in_bank, int_wr, cfg_wr;
  assign rel     = wr_addr - BANK_LO;
  assign in_bank = rel < ADDR_W'('h40);
  assign int_wr  = wr_en && in_bank && (rel[5:0] == 6'h0C);
  assign cfg_wr  = wr_en && in_bank && (rel[5:0] == 6'h08);

  assert_outside_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_bank) |=> ($stable(chan_en) && $stable(ie)));

  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (chan_en == $past(wr_data[0])));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_pulse |=> !sw_req_pulse);

  assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> pause_req);

  assert_ack_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> ($past(pause_req) && !$past(beat_busy)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts & $past(evt)) == $past(evt)));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr |=> ((sts & $past(wr_data[28:24] & ~evt)) == 5'b0));

  assert_irq_on_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && ie[0] && !wr_en) |=> irq);

  assert_cfgerr_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sts[4] |-> (xfer_done && irq));

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.ADDR_W(ADDR_W), .BANK_LO(BANK_LO)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .evt(evt), .beat_busy(beat_busy), .chan_en(chan_en), .pause_req(pause_req),
  .paused(paused), .sw_req_pulse(sw_req_pulse), .irq(irq), .xfer_done(xfer_done),
  .sts(sts), .ie(ie)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 'h1040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [4:0]  evt = '0;
  logic        beat_busy = 1'b0;
  logic        chan_en, llist_en, no_wait_bdone, sw_req_pulse;
  logic        pause_req, paused, irq, xfer_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.CHAN_IDX(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt(evt), .beat_busy(beat_busy),
    .chan_en(chan_en), .llist_en(llist_en), .no_wait_bdone(no_wait_bdone),
    .sw_req_pulse(sw_req_pulse), .pause_req(pause_req), .paused(paused),
    .irq(irq), .xfer_done(xfer_done)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [4:0] p);
    evt = p;
    cyc();
    evt = '0;
  endtask

  function automatic int top_level(input int m);
    int lv = 0;
    for (int b = 0; b < 5; b++) if (m[b]) lv = b + 1;
    return lv;
  endfunction

  logic [31:0] v;

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    rd(BASE + 'h00, v); check("R4 reset", v, 32'h0);
    rd(BASE + 'h08, v); check("R2 reset", v, 32'h0);
    rd(BASE + 'h0C, v); check("R5 reset", v, 32'h10);
    rd(BASE + 'h18, v); check("R10 reset", v, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);

    wr(BASE + 'h08, 32'h0100_0011);
    rd(BASE + 'h08, v); check("R2 cfg read", v, 32'h0100_0011);
    check("R2 cfg pins", {29'b0, no_wait_bdone, llist_en, chan_en}, 32'h7);
    wr(BASE + 'h08, 32'hFFFF_FFFF);
    rd(BASE + 'h08, v); check("R2 cfg reserved", v, 32'h0100_0011);
    wr(BASE + 'h08, 32'h0);
    check("R2 cfg clear", {29'b0, no_wait_bdone, llist_en, chan_en}, 32'h0);

    wr(16'h1008, 32'h1);
    wr(16'h1088, 32'h1);
    check("R1 foreign write", {31'b0, chan_en}, 32'h0);
    rd(16'h1008, v); check("R1 foreign read", v, 32'h0);
    wr(16'h100C, 32'h1);
    rd(BASE + 'h0C, v); check("R1 foreign int", v, 32'h10);

    wr(BASE + 'h04, 32'h1);
    check("R3 pulse", {31'b0, sw_req_pulse}, 32'h1);
    cyc();
    check("R3 pulse end", {31'b0, sw_req_pulse}, 32'h0);
    rd(BASE + 'h04, v); check("R3 read zero", v, 32'h0);
    wr(BASE + 'h04, 32'h0);
    check("R3 no pulse", {31'b0, sw_req_pulse}, 32'h0);

    beat_busy = 1'b1;
    wr(BASE + 'h00, 32'h1);
    rd(BASE + 'h00, v); check("R4 req busy", v, 32'h1);
    cyc(); cyc();
    rd(BASE + 'h00, v); check("R4 held busy", v, 32'h1);
    beat_busy = 1'b0;
    rd(BASE + 'h00, v); check("R4 before edge", v, 32'h1);
    cyc();
    rd(BASE + 'h00, v); check("R4 ack", v, 32'h5);
    beat_busy = 1'b1;
    cyc();
    check("R4 ack holds", {30'b0, pause_req, paused}, 32'h3);
    wr(BASE + 'h00, 32'h0);
    rd(BASE + 'h00, v); check("R4 resume", v, 32'h0);
    beat_busy = 1'b0;
    wr(BASE + 'h00, 32'h1);
    rd(BASE + 'h00, v); check("R4 idle req", v, 32'h1);
    cyc();
    rd(BASE + 'h00, v); check("R4 idle ack", v, 32'h5);
    wr(BASE + 'h00, 32'h0);

    wr(BASE + 'h0C, 32'h0000_01F0);
    rd(BASE + 'h0C, v); check("R5 cfgerr fixed", v, 32'h10);
    wr(BASE + 'h0C, 32'h0000_0005);
    rd(BASE + 'h0C, v); check("R5 enables", v, 32'h15);

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 32; p++) begin
        wr(BASE + 'h18, 32'(m) << 24);
        wr(BASE + 'h0C, 32'h1F00_000F);
        pulse(5'(p));
        rd(BASE + 'h0C, v);
        check("R6 status", v, 32'h1F | (32'(p) << 16));
        check("R9 irq", {31'b0, irq}, {31'b0, p != 0});
        check("R10 done", {31'b0, xfer_done},
              {31'b0, (p != 0) && (top_level(p) >= m + 1)});
      end
    end

    wr(BASE + 'h18, 32'h0);
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 5; s++) begin
        wr(BASE + 'h0C, 32'h1F00_0000 | 32'(e));
        pulse(5'(1 << s));
        rd(BASE + 'h0C, v);
        check("R6 single", v[20:16], 32'(1 << s));
        check("R9 masked irq", {31'b0, irq}, {31'b0, (s == 4) || e[s]});
        check("R10 masked done", {31'b0, xfer_done}, {31'b0, (s == 4) || e[s]});
      end
    end

    wr(BASE + 'h18, 32'h0200_0000);
    wr(BASE + 'h0C, 32'h1F00_0003);
    pulse(5'b00100);
    check("R10 disabled level", {31'b0, xfer_done}, 32'h0);

    wr(BASE + 'h0C, 32'h1F00_000F);
    pulse(5'h1F);
    wr(BASE + 'h0C, 32'h0A00_000F);
    rd(BASE + 'h0C, v); check("R7 partial clear", v, 32'h0015_001F);
    wr(BASE + 'h0C, 32'h0000_000F);
    rd(BASE + 'h0C, v); check("R7 zero keeps", v, 32'h0015_001F);

    wr(BASE + 'h0C, 32'h1F00_000F);
    evt = 5'b00001;
    wr(BASE + 'h0C, 32'h1F00_000F);
    evt = '0;
    rd(BASE + 'h0C, v); check("R8 set wins", v, 32'h0001_001F);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule